// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard keeper of a small out-of-order engine with two multiply units and one add unit over a register file of `NUM_REGS` entries. Each cycle it looks at the next in-order decoded instruction and decides whether the instruction may enter a unit. For each occupied unit it decides whether its two operands may be read, and for each unit that has finished it decides whether its result may be written back. The functional-unit arithmetic and the register file are outside the block. They act only on the three kinds of grant it produces.

Hazards are settled in separate phases with no renaming and no forwarding. Entry into a unit waits for a free unit of the right class and for no other in-flight instruction targeting the same destination. Operand read waits until both sources are produced. Result write waits until no other unit still has to read the old contents of the destination. Internally the block keeps a status record per unit, holding its phase, destination, sources, producer tags and ready flags. It also keeps a map from each register to the unit that will write it.

Top module: `scb_top`

## Requirements
- R1: After reset every unit is free and the register map is empty; with no instruction offered and no completions, `issueGrant`, `readGrant` and `writeGrant` are all 0.
- R2: Instructions are accepted in order. A multiply (`instIsAdd`=0) goes to multiplier 1 (unit code 0) when it is free, else to multiplier 2 (code 1). An add (`instIsAdd`=1) goes to the adder (code 2). `issueUnit` gives the code in the cycle `issueGrant` is 1.
- R3: An instruction whose unit class has no free unit is not accepted (`issueGrant`=0) and is held by the source.
- R4: An instruction is not accepted while any in-flight unit will write its destination register (WAW), even when a unit is free.
- R5: A unit gets `readGrant` only when both sources are available: a source is available at entry if no unit is pending on that register, otherwise once that producer writes.
- R6: A finished unit is refused `writeGrant` while another unit still holds its destination as an unread, available source (WAR). A consumer still waiting for that same register does not block.
- R7: A write grant frees the unit, clears its register-map entry and makes every source waiting on it available. This includes an instruction accepted in that same cycle.
- R8: At most one write grant per cycle, with priority multiplier 1, then multiplier 2, then adder.
- R9: A unit receiving a write grant cannot accept a new instruction in that cycle; it can in the next.
- R10: `execDone[u]` (bit 0 mult 1, bit 1 mult 2, bit 2 adder) only matters after unit u has read its operands. At any other time it has no effect. A write request appears in the cycle after an accepted `execDone`.
- R11: Reading operands releases the unit's claim on its source registers, so it no longer blocks writes to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | A decoded instruction is offered |
| instIsAdd | input | 1 | 1 = add class, 0 = multiply class |
| instDest | input | $clog2(NUM_REGS) | Destination register |
| instSrcA | input | $clog2(NUM_REGS) | First source register |
| instSrcB | input | $clog2(NUM_REGS) | Second source register |
| execDone | input | 3 | Per-unit execution finished pulse |
| issueGrant | output | 1 | Offered instruction is accepted this cycle |
| issueUnit | output | 2 | Unit code receiving the instruction |
| readGrant | output | 3 | Per-unit permission to read operands |
| writeGrant | output | 3 | Per-unit permission to write the result |

## Verification
A sequence of dependent instructions places a true dependency, an output dependency and an anti dependency in flight together. The bench then watches each grant release in the exact cycle its blocker clears, which separates stalls caused by a busy unit from stalls caused by a pending destination. Three independent instructions finishing together show the write priority order. A consumer accepted in the same cycle its producer writes shows whether the wakeup reaches a newly entered instruction. Completion pulses sent to idle or unread units show that they are ignored.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int NUM_UNITS = 3;
  localparam int UNIT_W    = 2;
  localparam int TAG_W     = 2;   // 0 = no producer, else unit code + 1

  localparam logic [UNIT_W-1:0] UNIT_MUL1 = 2'd0;
  localparam logic [UNIT_W-1:0] UNIT_MUL2 = 2'd1;
  localparam logic [UNIT_W-1:0] UNIT_ADD  = 2'd2;

  localparam logic [1:0] PH_IDLE    = 2'd0;
  localparam logic [1:0] PH_WAITOPS = 2'd1;
  localparam logic [1:0] PH_EXEC    = 2'd2;
  localparam logic [1:0] PH_WAITWR  = 2'd3;

  typedef struct packed {
    logic                 issueEn;
    logic [UNIT_W-1:0]    issueUnit;
    logic [TAG_W-1:0]     issueQa;
    logic [TAG_W-1:0]     issueQb;
    logic [TAG_W-1:0]     writerTag;
    logic [NUM_UNITS-1:0] readEn;
    logic [NUM_UNITS-1:0] doneEn;
    logic [NUM_UNITS-1:0] writeEn;
  } scbStrobe_t;
endpackage

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                                instValid,
  input  logic                                instIsAdd,
  input  logic [REG_W-1:0]                    instDest,
  input  logic [REG_W-1:0]                    instSrcA,
  input  logic [REG_W-1:0]                    instSrcB,
  input  logic [NUM_UNITS-1:0]                execDone,
  input  logic [NUM_UNITS-1:0][1:0]           unitPhase,
  input  logic [NUM_UNITS-1:0][REG_W-1:0]     unitDest,
  input  logic [NUM_UNITS-1:0][REG_W-1:0]     unitSrcA,
  input  logic [NUM_UNITS-1:0][REG_W-1:0]     unitSrcB,
  input  logic [NUM_UNITS-1:0]                unitRdyA,
  input  logic [NUM_UNITS-1:0]                unitRdyB,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]      regMap,
  output scbStrobe_t                          strobe
);
  logic [NUM_UNITS-1:0] unitFree;
  logic [NUM_UNITS-1:0] warBlock;
  logic [NUM_UNITS-1:0] writeReq;
  logic [NUM_UNITS-1:0] writeSel;
  logic [TAG_W-1:0]     writerTag;
  logic                 candOk;
  logic [UNIT_W-1:0]    candUnit;
  logic                 wawHit;

  // Unit status decode and anti-dependency check
  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      unitFree[u] = (unitPhase[u] == PH_IDLE);
      warBlock[u] = 1'b0;
      for (int v = 0; v < NUM_UNITS; v++) begin
        if (v != u && unitPhase[v] != PH_IDLE) begin
          if ((unitSrcA[v] == unitDest[u] && unitRdyA[v]) ||
              (unitSrcB[v] == unitDest[u] && unitRdyB[v]))
            warBlock[u] = 1'b1;
        end
      end
      writeReq[u] = (unitPhase[u] == PH_WAITWR) && !warBlock[u];
    end
  end

  // Fixed-priority single write grant, lowest unit code first
  always_comb begin
    logic found;
    found     = 1'b0;
    writeSel  = '0;
    writerTag = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (!found && writeReq[u]) begin
        found       = 1'b1;
        writeSel[u] = 1'b1;
        writerTag   = TAG_W'(u + 1);
      end
    end
  end

  // Unit selection for the offered instruction
  always_comb begin
    candOk   = 1'b0;
    candUnit = UNIT_MUL1;
    if (instIsAdd) begin
      candOk   = unitFree[UNIT_ADD];
      candUnit = UNIT_ADD;
    end else if (unitFree[UNIT_MUL1]) begin
      candOk   = 1'b1;
      candUnit = UNIT_MUL1;
    end else if (unitFree[UNIT_MUL2]) begin
      candOk   = 1'b1;
      candUnit = UNIT_MUL2;
    end
    wawHit = (regMap[instDest] != '0);
  end

  always_comb begin
    strobe           = '0;
    strobe.issueEn   = instValid && candOk && !wawHit;
    strobe.issueUnit = candUnit;
    // A producer writing this very cycle counts as already available
    strobe.issueQa   = (regMap[instSrcA] == writerTag) ? '0 : regMap[instSrcA];
    strobe.issueQb   = (regMap[instSrcB] == writerTag) ? '0 : regMap[instSrcB];
    strobe.writerTag = writerTag;
    strobe.writeEn   = writeSel;
    for (int u = 0; u < NUM_UNITS; u++) begin
      strobe.readEn[u] = (unitPhase[u] == PH_WAITOPS) && unitRdyA[u] && unitRdyB[u];
      strobe.doneEn[u] = (unitPhase[u] == PH_EXEC) && execDone[u];
    end
  end
endmodule

// File: rtl/scb_status.sv
module scb_status
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  scbStrobe_t                          strobe,
  input  logic [REG_W-1:0]                    instDest,
  input  logic [REG_W-1:0]                    instSrcA,
  input  logic [REG_W-1:0]                    instSrcB,
  output logic [NUM_UNITS-1:0][1:0]           unitPhase,
  output logic [NUM_UNITS-1:0][REG_W-1:0]     unitDest,
  output logic [NUM_UNITS-1:0][REG_W-1:0]     unitSrcA,
  output logic [NUM_UNITS-1:0][REG_W-1:0]     unitSrcB,
  output logic [NUM_UNITS-1:0]                unitRdyA,
  output logic [NUM_UNITS-1:0]                unitRdyB,
  output logic [NUM_REGS-1:0][TAG_W-1:0]      regMap
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [1:0]       ph;
    logic [REG_W-1:0] fDest, fSrcA, fSrcB;
    logic [TAG_W-1:0] qA, qB;
    logic             rA, rB;
    logic             takeIssue;

    assign takeIssue = strobe.issueEn && (strobe.issueUnit == UNIT_W'(u));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph    <= PH_IDLE;
        fDest <= '0;
        fSrcA <= '0;
        fSrcB <= '0;
        qA    <= '0;
        qB    <= '0;
        rA    <= 1'b0;
        rB    <= 1'b0;
      end else if (strobe.writeEn[u]) begin
        ph <= PH_IDLE;
      end else if (strobe.doneEn[u]) begin
        ph <= PH_WAITWR;
      end else if (strobe.readEn[u]) begin
        ph <= PH_EXEC;
        rA <= 1'b0;
        rB <= 1'b0;
        qA <= '0;
        qB <= '0;
      end else if (takeIssue) begin
        ph    <= PH_WAITOPS;
        fDest <= instDest;
        fSrcA <= instSrcA;
        fSrcB <= instSrcB;
        qA    <= strobe.issueQa;
        qB    <= strobe.issueQb;
        rA    <= (strobe.issueQa == '0);
        rB    <= (strobe.issueQb == '0);
      end else if (ph == PH_WAITOPS && strobe.writerTag != '0) begin
        if (qA == strobe.writerTag) begin
          rA <= 1'b1;
          qA <= '0;
        end
        if (qB == strobe.writerTag) begin
          rB <= 1'b1;
          qB <= '0;
        end
      end
    end

    assign unitPhase[u] = ph;
    assign unitDest[u]  = fDest;
    assign unitSrcA[u]  = fSrcA;
    assign unitSrcB[u]  = fSrcB;
    assign unitRdyA[u]  = rA;
    assign unitRdyB[u]  = rB;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [TAG_W-1:0] owner;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        owner <= '0;
      else if (strobe.issueEn && instDest == REG_W'(r))
        owner <= TAG_W'(strobe.issueUnit) + TAG_W'(1);
      else if (strobe.writerTag != '0 && owner == strobe.writerTag)
        owner <= '0;
    end
    assign regMap[r] = owner;
  end
endmodule

// File: rtl/scb_top.sv
module scb_top
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instValid,
  input  logic             instIsAdd,
  input  logic [REG_W-1:0] instDest,
  input  logic [REG_W-1:0] instSrcA,
  input  logic [REG_W-1:0] instSrcB,
  input  logic [2:0]       execDone,
  output logic             issueGrant,
  output logic [1:0]       issueUnit,
  output logic [2:0]       readGrant,
  output logic [2:0]       writeGrant
);
  scbStrobe_t                       strobe;
  logic [NUM_UNITS-1:0][1:0]        unitPhase;
  logic [NUM_UNITS-1:0][REG_W-1:0]  unitDest, unitSrcA, unitSrcB;
  logic [NUM_UNITS-1:0]             unitRdyA, unitRdyB;
  logic [NUM_REGS-1:0][TAG_W-1:0]   regMap;

  scb_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .instValid (instValid),
    .instIsAdd (instIsAdd),
    .instDest  (instDest),
    .instSrcA  (instSrcA),
    .instSrcB  (instSrcB),
    .execDone  (execDone),
    .unitPhase (unitPhase),
    .unitDest  (unitDest),
    .unitSrcA  (unitSrcA),
    .unitSrcB  (unitSrcB),
    .unitRdyA  (unitRdyA),
    .unitRdyB  (unitRdyB),
    .regMap    (regMap),
    .strobe    (strobe)
  );

  scb_status #(.NUM_REGS(NUM_REGS)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .instDest  (instDest),
    .instSrcA  (instSrcA),
    .instSrcB  (instSrcB),
    .unitPhase (unitPhase),
    .unitDest  (unitDest),
    .unitSrcA  (unitSrcA),
    .unitSrcB  (unitSrcB),
    .unitRdyA  (unitRdyA),
    .unitRdyB  (unitRdyB),
    .regMap    (regMap)
  );

  assign issueGrant = strobe.issueEn;
  assign issueUnit  = strobe.issueUnit;
  assign readGrant  = strobe.readEn;
  assign writeGrant = strobe.writeEn;
endmodule

// File: rtl/scb_checker.sv
module scb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       issueGrant,
  input logic [1:0] issueUnit,
  input logic [2:0] readGrant,
  input logic [2:0] writeGrant
);
  assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(writeGrant));

  assert_valid_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issueGrant |-> issueUnit != 2'd3);

  for (genvar u = 0; u < 3; u++) begin : g_chk
    assert_no_issue_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      writeGrant[u] |-> !(issueGrant && issueUnit == 2'(u)));

    assert_no_read_at_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issueGrant && issueUnit == 2'(u)) |-> !readGrant[u]);

    assert_done_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      readGrant[u] |=> !writeGrant[u]);

    assert_free_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      writeGrant[u] |=> !writeGrant[u]);
  end
endmodule

bind scb_top scb_checker u_scb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .issueGrant (issueGrant),
  .issueUnit  (issueUnit),
  .readGrant  (readGrant),
  .writeGrant (writeGrant)
);

// File: tb/tb_scb_top.sv
module tb_scb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instValid = 1'b0;
  logic       instIsAdd = 1'b0;
  logic [3:0] instDest = '0;
  logic [3:0] instSrcA = '0;
  logic [3:0] instSrcB = '0;
  logic [2:0] execDone = '0;
  logic       issueGrant;
  logic [1:0] issueUnit;
  logic [2:0] readGrant;
  logic [2:0] writeGrant;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic       iss;
    logic [1:0] unit;
    logic [2:0] rd;
    logic [2:0] wr;
    string      req;
  } expItem_t;

  expItem_t expQ[$];

  always #5 clk = ~clk;

  scb_top #(.NUM_REGS(16)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .instValid  (instValid),
    .instIsAdd  (instIsAdd),
    .instDest   (instDest),
    .instSrcA   (instSrcA),
    .instSrcB   (instSrcB),
    .execDone   (execDone),
    .issueGrant (issueGrant),
    .issueUnit  (issueUnit),
    .readGrant  (readGrant),
    .writeGrant (writeGrant)
  );

  // Driver: one cycle of stimulus plus the grants expected in that cycle
  task automatic step(input logic v, input logic add, input int d, input int a,
                      input int b, input logic [2:0] done, input logic eIss,
                      input logic [1:0] eUnit, input logic [2:0] eRd,
                      input logic [2:0] eWr, input string req);
    expItem_t it;
    @(negedge clk);
    instValid = v;
    instIsAdd = add;
    instDest  = 4'(d);
    instSrcA  = 4'(a);
    instSrcB  = 4'(b);
    execDone  = done;
    it.iss = eIss; it.unit = eUnit; it.rd = eRd; it.wr = eWr; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: compares settled outputs well after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (issueGrant !== e.iss || (e.iss && issueUnit !== e.unit) ||
            readGrant !== e.rd || writeGrant !== e.wr) begin
          failures++;
          $display("FAIL %s: got iss=%0b unit=%0d rd=%03b wr=%03b, expected iss=%0b unit=%0d rd=%03b wr=%03b",
                   e.req, issueGrant, issueUnit, readGrant, writeGrant,
                   e.iss, e.unit, e.rd, e.wr);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 idle after reset
    step(0,0,0,0,0,3'b000, 0,0,3'b000,3'b000, "R1");
    // R2 mult to mult1, then mult2 while mult1 busy; mult1 reads at once
    step(1,0,4,0,2,3'b000, 1,0,3'b000,3'b000, "R2");
    step(1,0,6,4,8,3'b000, 1,1,3'b001,3'b000, "R2");
    // R5 mult2 waits on R4 from mult1; add enters the adder
    step(1,1,8,2,12,3'b000, 1,2,3'b000,3'b000, "R5");
    // R3 adder busy (and R4 dest pending): held
    step(1,1,4,14,15,3'b000, 0,0,3'b100,3'b000, "R3");
    step(1,1,4,14,15,3'b100, 0,0,3'b000,3'b000, "R4");
    // R6 adder result to R8 blocked: mult2 still must read R8
    step(1,1,4,14,15,3'b000, 0,0,3'b000,3'b000, "R6");
    step(1,1,4,14,15,3'b001, 0,0,3'b000,3'b000, "R6");
    // R7 mult1 writes R4, waking mult2
    step(1,1,4,14,15,3'b000, 0,0,3'b000,3'b001, "R7");
    step(1,1,4,14,15,3'b000, 0,0,3'b010,3'b000, "R7");
    // R11 after mult2 read, adder may write; R9 no entry same cycle
    step(1,1,4,14,15,3'b000, 0,0,3'b000,3'b100, "R11 R9");
    step(1,1,4,14,15,3'b000, 1,2,3'b000,3'b000, "R9");
    step(0,0,0,0,0,3'b010, 0,0,3'b100,3'b000, "R5");
    step(0,0,0,0,0,3'b100, 0,0,3'b000,3'b010, "R7");
    step(0,0,0,0,0,3'b000, 0,0,3'b000,3'b100, "R7");
    // R8 three independent ops finishing together
    step(1,0,1,2,3,3'b000, 1,0,3'b000,3'b000, "R2");
    step(1,0,5,2,3,3'b000, 1,1,3'b001,3'b000, "R2");
    step(1,1,7,2,3,3'b000, 1,2,3'b010,3'b000, "R2");
    step(0,0,0,0,0,3'b011, 0,0,3'b100,3'b000, "R5");
    step(0,0,0,0,0,3'b100, 0,0,3'b000,3'b001, "R8");
    step(0,0,0,0,0,3'b000, 0,0,3'b000,3'b010, "R8");
    step(0,0,0,0,0,3'b000, 0,0,3'b000,3'b100, "R8");
    // R10 completion pulses to idle / not-yet-read units ignored
    step(0,0,0,0,0,3'b111, 0,0,3'b000,3'b000, "R10");
    step(1,0,9,1,1,3'b111, 1,0,3'b000,3'b000, "R10");
    step(0,0,0,0,0,3'b000, 0,0,3'b001,3'b000, "R10");
    step(0,0,0,0,0,3'b001, 0,0,3'b000,3'b000, "R10");
    // R7 consumer of R9 enters while R9 is written: becomes ready
    step(1,1,10,9,9,3'b000, 1,2,3'b000,3'b001, "R7");
    step(1,0,11,10,0,3'b000, 1,0,3'b100,3'b000, "R7");
    // R4 mult2 free but R10 still pending
    step(1,0,10,0,0,3'b100, 0,0,3'b000,3'b000, "R4");
    // R6 waiting consumer of R10 does not block its producer
    step(0,0,0,0,0,3'b000, 0,0,3'b000,3'b100, "R6");
    step(0,0,0,0,0,3'b000, 0,0,3'b001,3'b000, "R7");
    step(0,0,0,0,0,3'b001, 0,0,3'b000,3'b000, "R5");
    step(0,0,0,0,0,3'b000, 0,0,3'b000,3'b001, "R7");
    step(0,0,0,0,0,3'b000, 0,0,3'b000,3'b000, "R1");

    @(negedge clk);
    instValid = 1'b0;
    execDone  = '0;
    while (expQ.size() > 0) @(negedge clk);
    #5;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule